// File: doc/BRIEF.md
# Processor Trap Entry Controller

This block carries out the architectural state change a processor core makes when it takes a trap. Four kinds of trap are handled: break, program, software and external interrupt. When a trap is taken, the block saves the interrupted PC and the old status bits, moves the core into supervisor mode with traps disabled, and writes a new vector index into the trap vector register. It then sends the core a one-cycle redirect to the resulting handler address. Break traps use their own save registers and set a debug-mode flag. Program and software traps share the normal save path.

A program or software trap can arrive while traps are disabled. The state change still takes place, and the core then enters a stopped state that only reset clears. External interrupt levels are held in a small pending store. The highest pending level is offered each cycle and is accepted only when traps are enabled and the level is not below the interrupt floor. An accepted level leaves the store. A rejected level stays pending and is offered again on later cycles. Control writes let the core's instruction path load the status fields and the base of the trap vector register.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset: supervisor bit 1, previous-supervisor bit 0, trap-enable 0, interrupt floor 0. Both break save bits are 0. Both saved PCs are 0. The vector register is 0. Redirect, debug mode, halted, pending count and overflow are all 0.
- R2: A break trap (trap_kind 2) copies the supervisor bit into brk_sup and the trap-enable bit into brk_trap_en. It then sets the supervisor bit to 1 and trap-enable to 0, stores pc_cur in brk_save_pc and sets debug_mode. It leaves prev_sup and save_pc unchanged. A break is taken even when traps are disabled.
- R3: The vector register reads as {base[31:12], index[11:4], 4'b0000}. A break writes index 0xFF. Every taken trap raises redirect_valid for one cycle, in the cycle after the request edge, with redirect_pc equal to the new vector register value.
- R4: A program trap (trap_kind 0) or software trap (trap_kind 1 or 3) copies the supervisor bit into prev_sup, sets the supervisor bit to 1 and trap-enable to 0, and writes trap_offset as the vector index.
- R5: For a precise program or software trap, save_pc receives pc_prev. For an imprecise one, save_pc receives pc_cur.
- R6: If trap-enable is 0 when a program or software trap is taken, the full state update still occurs and halted rises with the redirect. While halted, no trap of any kind is taken. Only reset clears halted.
- R7: The pending external level L is accepted only when trap-enable is 1 and L >= irq_floor. Level 15 is always accepted when traps are enabled. An accepted level writes vector index 0x10+L, stores pc_cur in save_pc, copies the supervisor bit into prev_sup, and is removed from the pending store.
- R8: A pending level that is rejected stays in the store. The pending count does not change, and no redirect is raised.
- R9: When several levels are pending, the highest level is offered first.
- R10: The store holds up to 8 levels. A push while it is full is dropped, and q_overflow rises and stays set until reset.
- R11: A break or program/software request in the same cycle as an acceptable external level is taken instead of it, and the external level stays pending.
- R12: wr_stat loads the supervisor bit, trap-enable and interrupt floor. wr_vec loads the vector base. Both writes are dropped in a cycle in which a trap is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Break, program or software trap request |
| trap_kind | input | 2 | 0 program, 1/3 software, 2 break |
| trap_precise | input | 1 | Request is precise |
| trap_offset | input | 8 | Handler vector index for program/software traps |
| pc_cur | input | 32 | Current PC |
| pc_prev | input | 32 | PC of the previous instruction packet |
| ext_push | input | 1 | Push an external interrupt level |
| ext_level | input | 4 | Level being pushed |
| wr_stat | input | 1 | Load status fields |
| wr_sup | input | 1 | Supervisor bit to load |
| wr_trap_en | input | 1 | Trap-enable bit to load |
| wr_floor | input | 4 | Interrupt floor to load |
| wr_vec | input | 1 | Load vector base |
| wr_vec_base | input | 20 | Vector base bits 31:12 |
| redirect_valid | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | 32 | Handler address |
| debug_mode | output | 1 | Set by a break trap |
| halted | output | 1 | Stopped state |
| sup | output | 1 | Supervisor bit |
| prev_sup | output | 1 | Previous supervisor bit |
| trap_en | output | 1 | Trap-enable bit |
| irq_floor | output | 4 | Interrupt floor |
| brk_sup | output | 1 | Supervisor bit saved by break |
| brk_trap_en | output | 1 | Trap-enable saved by break |
| save_pc | output | 32 | Saved PC, normal traps |
| brk_save_pc | output | 32 | Saved PC, break traps |
| vec_reg | output | 32 | Trap vector register |
| q_count | output | 4 | Pending level count |
| q_overflow | output | 1 | Sticky push-drop flag |

## Verification
The assertions check the following on every cycle:
- each redirect leaves the core in supervisor mode with traps disabled;
- the redirect address equals the vector register and is 16-byte aligned;
- a rise of debug mode comes with index 0xFF;
- halted never falls and rises only after a trap taken with traps disabled;
- the pending count stays within bounds, and overflow rises only on a push into a full store.

Only the directed scenarios can show which PC is saved, how precision selects it, and that the masking floor is compared correctly. The same holds for the highest-first order of pending levels, the winner when a synchronous trap collides with an external one, and that control writes are dropped when a trap is taken.

// File: rtl/trap_pkg.sv
// Shared types and constants for the trap entry controller.
// Assumes an 8-bit vector index placed directly above a 4-bit alignment gap.
package trap_pkg;
    typedef enum logic [1:0] {
        TK_PROGRAM  = 2'd0,
        TK_SOFTWARE = 2'd1,
        TK_BREAK    = 2'd2
    } trap_kind_e;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_BREAK = 2'd1,
        SEL_SYNC  = 2'd2,
        SEL_EXT   = 2'd3
    } trap_sel_e;

    localparam logic [7:0] BREAK_INDEX    = 8'hFF;
    localparam logic [7:0] EXT_INDEX_BASE = 8'h10;
endpackage

// File: rtl/trap_ext_queue.sv
// Pending store for external interrupt levels.
// Slots are unordered. The head is the highest pending level (lowest slot wins a tie).
// A push into a full store is dropped and sets a sticky overflow flag.
// Pop and push may occur in the same cycle. A pop never targets the slot a push fills.
module trap_ext_queue #(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LVL_W-1:0] push_level,
    input  logic             pop,
    output logic             head_valid,
    output logic [LVL_W-1:0] head_level,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);
    logic [DEPTH-1:0] vld;
    logic [LVL_W-1:0] lvl [DEPTH];
    logic [IDX_W-1:0] head_idx;
    logic [IDX_W-1:0] free_idx;
    logic             full;

    // Pick the highest pending level as head.
    always_comb begin
        head_valid = 1'b0;
        head_level = '0;
        head_idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld[i] && (!head_valid || lvl[i] > head_level)) begin
                head_valid = 1'b1;
                head_level = lvl[i];
                head_idx   = IDX_W'(i);
            end
        end
    end

    // Find the lowest free slot and count occupancy.
    always_comb begin
        free_idx = '0;
        count    = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld[i]) free_idx = IDX_W'(i);
        end
        for (int i = 0; i < DEPTH; i++) begin
            count = count + CNT_W'(vld[i]);
        end
        full = &vld;
    end

    // Slot valid bits and the overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld      <= '0;
            overflow <= 1'b0;
        end else begin
            if (pop && head_valid) vld[head_idx] <= 1'b0;
            if (push && !full)     vld[free_idx] <= 1'b1;
            if (push && full)      overflow      <= 1'b1;
        end
    end

    // Slot level storage. No reset is needed: a slot's level is read only while its valid bit is set.
    always_ff @(posedge clk) begin
        if (push && !full) lvl[free_idx] <= push_level;
    end

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_overflow_on_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(count) == CNT_W'(DEPTH));
    assert_pop_has_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);
endmodule

// File: rtl/trap_arbiter.sv
// Chooses at most one trap per cycle: break, then program/software, then external.
// Also gives the new vector index.
// Assumes the synchronous request is valid for exactly the cycle it is presented.
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int LVL_W = 4,
    parameter int IDX_W = 8
) (
    input  logic             halted,
    input  logic             trap_req,
    input  logic [1:0]       trap_kind,
    input  logic [IDX_W-1:0] trap_offset,
    input  logic             trap_en,
    input  logic [LVL_W-1:0] irq_floor,
    input  logic             head_valid,
    input  logic [LVL_W-1:0] head_level,
    output trap_sel_e        sel,
    output logic [IDX_W-1:0] new_index,
    output logic             ext_pop
);
    localparam logic [LVL_W-1:0] LVL_TOP = '1;

    logic ext_ok;

    // Masking test for the offered external level.
    always_comb begin
        ext_ok = head_valid && trap_en && (head_level == LVL_TOP || head_level >= irq_floor);
    end

    // Priority selection and vector index.
    always_comb begin
        sel       = SEL_NONE;
        new_index = '0;
        if (!halted) begin
            if (trap_req && trap_kind == TK_BREAK) begin
                sel       = SEL_BREAK;
                new_index = IDX_W'(BREAK_INDEX);
            end else if (trap_req) begin
                sel       = SEL_SYNC;
                new_index = trap_offset;
            end else if (ext_ok) begin
                sel       = SEL_EXT;
                new_index = IDX_W'(EXT_INDEX_BASE) + IDX_W'(head_level);
            end
        end
        ext_pop = (sel == SEL_EXT);
    end
endmodule

// File: rtl/trap_entry_ctrl.sv
// Trap entry controller top.
// Holds the status, break-save, saved-PC and vector registers and updates them when a trap is taken.
// Assumes a synchronous active-low reset. The redirect is registered and is valid one cycle after the taking edge.
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 8,
    parameter int ALIGN  = 4,
    parameter int LVL_W  = 4,
    parameter int QDEPTH = 8,
    localparam int BASE_W = PC_W - IDX_W - ALIGN,
    localparam int CNT_W  = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic [1:0]        trap_kind,
    input  logic              trap_precise,
    input  logic [IDX_W-1:0]  trap_offset,
    input  logic [PC_W-1:0]   pc_cur,
    input  logic [PC_W-1:0]   pc_prev,
    input  logic              ext_push,
    input  logic [LVL_W-1:0]  ext_level,
    input  logic              wr_stat,
    input  logic              wr_sup,
    input  logic              wr_trap_en,
    input  logic [LVL_W-1:0]  wr_floor,
    input  logic              wr_vec,
    input  logic [BASE_W-1:0] wr_vec_base,
    output logic              redirect_valid,
    output logic [PC_W-1:0]   redirect_pc,
    output logic              debug_mode,
    output logic              halted,
    output logic              sup,
    output logic              prev_sup,
    output logic              trap_en,
    output logic [LVL_W-1:0]  irq_floor,
    output logic              brk_sup,
    output logic              brk_trap_en,
    output logic [PC_W-1:0]   save_pc,
    output logic [PC_W-1:0]   brk_save_pc,
    output logic [PC_W-1:0]   vec_reg,
    output logic [CNT_W-1:0]  q_count,
    output logic              q_overflow
);
    logic [BASE_W-1:0] vec_base;
    logic [IDX_W-1:0]  vec_index;
    logic              head_valid;
    logic [LVL_W-1:0]  head_level;
    trap_sel_e         sel;
    logic [IDX_W-1:0]  new_index;
    logic              ext_pop;

    assign vec_reg = {vec_base, vec_index, {ALIGN{1'b0}}};

    trap_ext_queue #(.DEPTH(QDEPTH), .LVL_W(LVL_W)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (ext_push),
        .push_level (ext_level),
        .pop        (ext_pop),
        .head_valid (head_valid),
        .head_level (head_level),
        .count      (q_count),
        .overflow   (q_overflow)
    );

    trap_arbiter #(.LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
        .halted      (halted),
        .trap_req    (trap_req),
        .trap_kind   (trap_kind),
        .trap_offset (trap_offset),
        .trap_en     (trap_en),
        .irq_floor   (irq_floor),
        .head_valid  (head_valid),
        .head_level  (head_level),
        .sel         (sel),
        .new_index   (new_index),
        .ext_pop     (ext_pop)
    );

    // Architectural state update for the selected trap, or control writes when no trap is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sup            <= 1'b1;
            prev_sup       <= 1'b0;
            trap_en        <= 1'b0;
            irq_floor      <= '0;
            brk_sup        <= 1'b0;
            brk_trap_en    <= 1'b0;
            save_pc        <= '0;
            brk_save_pc    <= '0;
            vec_base       <= '0;
            vec_index      <= '0;
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            debug_mode     <= 1'b0;
            halted         <= 1'b0;
        end else begin
            redirect_valid <= (sel != SEL_NONE);
            redirect_pc    <= '0;
            case (sel)
                SEL_BREAK: begin
                    brk_sup     <= sup;
                    brk_trap_en <= trap_en;
                    sup         <= 1'b1;
                    trap_en     <= 1'b0;
                    brk_save_pc <= pc_cur;
                    vec_index   <= new_index;
                    redirect_pc <= {vec_base, new_index, {ALIGN{1'b0}}};
                    debug_mode  <= 1'b1;
                end
                SEL_SYNC: begin
                    prev_sup    <= sup;
                    sup         <= 1'b1;
                    trap_en     <= 1'b0;
                    save_pc     <= trap_precise ? pc_prev : pc_cur;
                    vec_index   <= new_index;
                    redirect_pc <= {vec_base, new_index, {ALIGN{1'b0}}};
                    if (!trap_en) halted <= 1'b1;
                end
                SEL_EXT: begin
                    prev_sup    <= sup;
                    sup         <= 1'b1;
                    trap_en     <= 1'b0;
                    save_pc     <= pc_cur;
                    vec_index   <= new_index;
                    redirect_pc <= {vec_base, new_index, {ALIGN{1'b0}}};
                end
                default: begin
                    if (wr_stat) begin
                        sup       <= wr_sup;
                        trap_en   <= wr_trap_en;
                        irq_floor <= wr_floor;
                    end
                    if (wr_vec) vec_base <= wr_vec_base;
                end
            endcase
        end
    end

    assert_trap_enters_super_R4: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (sup && !trap_en));
    assert_redirect_matches_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> redirect_pc == vec_reg);
    assert_redirect_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_pc[ALIGN-1:0] == '0);
    assert_debug_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(debug_mode) |-> vec_reg[ALIGN+IDX_W-1:ALIGN] == IDX_W'(BREAK_INDEX));
    assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    assert_halt_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> (redirect_valid && !$past(trap_en)));
endmodule

// File: tb/trap_entry_ctrl_test.sv
module trap_entry_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        trap_req, trap_precise, ext_push, wr_stat, wr_sup, wr_trap_en, wr_vec;
    logic [1:0]  trap_kind;
    logic [7:0]  trap_offset;
    logic [31:0] pc_cur, pc_prev;
    logic [3:0]  ext_level, wr_floor;
    logic [19:0] wr_vec_base;
    logic        redirect_valid, debug_mode, halted, sup, prev_sup, trap_en;
    logic        brk_sup, brk_trap_en, q_overflow;
    logic [31:0] redirect_pc, save_pc, brk_save_pc, vec_reg;
    logic [3:0]  irq_floor, q_count;

    int n_chk = 0;
    int n_fail = 0;

    trap_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_kind(trap_kind),
        .trap_precise(trap_precise), .trap_offset(trap_offset), .pc_cur(pc_cur),
        .pc_prev(pc_prev), .ext_push(ext_push), .ext_level(ext_level),
        .wr_stat(wr_stat), .wr_sup(wr_sup), .wr_trap_en(wr_trap_en), .wr_floor(wr_floor),
        .wr_vec(wr_vec), .wr_vec_base(wr_vec_base), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .debug_mode(debug_mode), .halted(halted), .sup(sup),
        .prev_sup(prev_sup), .trap_en(trap_en), .irq_floor(irq_floor), .brk_sup(brk_sup),
        .brk_trap_en(brk_trap_en), .save_pc(save_pc), .brk_save_pc(brk_save_pc),
        .vec_reg(vec_reg), .q_count(q_count), .q_overflow(q_overflow)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        trap_req = 0; trap_kind = 0; trap_precise = 0; trap_offset = 0;
        pc_cur = 0; pc_prev = 0; ext_push = 0; ext_level = 0;
        wr_stat = 0; wr_sup = 0; wr_trap_en = 0; wr_floor = 0; wr_vec = 0; wr_vec_base = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        step(); step();
        rst_n = 1;
        step();
    endtask

    // One-cycle status write, applied at the next edge.
    task automatic write_stat(input logic s, input logic et, input logic [3:0] fl);
        wr_stat = 1; wr_sup = s; wr_trap_en = et; wr_floor = fl;
        step();
        wr_stat = 0;
    endtask

    task automatic write_base(input logic [19:0] b);
        wr_vec = 1; wr_vec_base = b;
        step();
        wr_vec = 0;
    endtask

    task automatic push_level(input logic [3:0] l);
        ext_push = 1; ext_level = l;
        step();
        ext_push = 0;
    endtask

    task automatic sync_trap(input logic [1:0] k, input logic prec, input logic [7:0] off,
                             input logic [31:0] pcc, input logic [31:0] pcp);
        trap_req = 1; trap_kind = k; trap_precise = prec; trap_offset = off;
        pc_cur = pcc; pc_prev = pcp;
        step();
        trap_req = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 sup", 32'(sup), 1);
        chk("R1 prev_sup", 32'(prev_sup), 0);
        chk("R1 trap_en", 32'(trap_en), 0);
        chk("R1 floor", 32'(irq_floor), 0);
        chk("R1 brk bits", 32'({brk_sup, brk_trap_en}), 0);
        chk("R1 saved pcs", save_pc | brk_save_pc, 0);
        chk("R1 vec", vec_reg, 0);
        chk("R1 flags", 32'({redirect_valid, debug_mode, halted, q_overflow}), 0);
        chk("R1 count", 32'(q_count), 0);
    endtask

    task automatic t_break();
        do_reset();
        write_base(20'hABCDE);
        write_stat(0, 1, 4'd3);
        sync_trap(2'd2, 0, 8'h00, 32'h0000_1000, 32'h0000_0FF0);
        chk("R2 brk_sup", 32'(brk_sup), 0);
        chk("R2 brk_trap_en", 32'(brk_trap_en), 1);
        chk("R2 sup/en", 32'({sup, trap_en}), 32'b10);
        chk("R2 brk_save_pc", brk_save_pc, 32'h0000_1000);
        chk("R2 save_pc untouched", save_pc, 0);
        chk("R2 debug", 32'(debug_mode), 1);
        chk("R3 vec break index", vec_reg, 32'hABCD_EFF0);
        chk("R3 redirect valid", 32'(redirect_valid), 1);
        chk("R3 redirect pc", redirect_pc, 32'hABCD_EFF0);
        step();
        chk("R3 redirect one cycle", 32'(redirect_valid), 0);
        // A second break while traps are disabled is still taken.
        sync_trap(2'd2, 0, 8'h00, 32'h0000_2000, 32'h0);
        chk("R2 break with traps off", brk_save_pc, 32'h0000_2000);
        chk("R2 saved sup", 32'({brk_sup, brk_trap_en}), 32'b10);
    endtask

    task automatic t_program_precise();
        do_reset();
        write_base(20'h00001);
        write_stat(1, 1, 4'd0);
        sync_trap(2'd0, 1, 8'h23, 32'h0000_0204, 32'h0000_0200);
        chk("R4 prev_sup", 32'(prev_sup), 1);
        chk("R4 sup/en", 32'({sup, trap_en}), 32'b10);
        chk("R5 precise save", save_pc, 32'h0000_0200);
        chk("R4 redirect", redirect_pc, 32'h0000_1230);
        chk("R4 not halted", 32'(halted), 0);
        chk("R4 brk pc untouched", brk_save_pc, 0);
    endtask

    task automatic t_software_imprecise();
        do_reset();
        write_stat(0, 1, 4'd0);
        sync_trap(2'd1, 0, 8'h41, 32'h0000_0304, 32'h0000_0300);
        chk("R5 imprecise save", save_pc, 32'h0000_0304);
        chk("R4 prev_sup from user", 32'(prev_sup), 0);
        chk("R4 index", vec_reg, 32'h0000_0410);
    endtask

    task automatic t_halt();
        do_reset();
        sync_trap(2'd0, 0, 8'h07, 32'h0000_0500, 32'h0);
        chk("R6 halted", 32'(halted), 1);
        chk("R6 still redirected", 32'(redirect_valid), 1);
        chk("R6 state updated", save_pc, 32'h0000_0500);
        chk("R6 index", vec_reg, 32'h0000_0070);
        sync_trap(2'd2, 0, 8'h00, 32'h0000_0600, 32'h0);
        chk("R6 no trap while halted", 32'(redirect_valid), 0);
        chk("R6 break ignored", brk_save_pc, 0);
        step();
        chk("R6 halt sticky", 32'(halted), 1);
    endtask

    task automatic t_ext_mask();
        do_reset();
        pc_cur = 32'h0000_0800;
        push_level(4'd5);
        write_stat(0, 1, 4'd6);
        step(); step();
        chk("R8 rejected stays", 32'(q_count), 1);
        chk("R8 no redirect", 32'(redirect_valid), 0);
        write_stat(0, 1, 4'd15);
        push_level(4'd15);
        step();
        chk("R7 level 15 taken", 32'(redirect_valid), 1);
        chk("R7 index 15", vec_reg, 32'h0000_01F0);
        chk("R7 save cur pc", save_pc, 32'h0000_0800);
        chk("R7 popped", 32'(q_count), 1);
        write_stat(1, 1, 4'd5);
        step();
        chk("R7 level equal floor", vec_reg, 32'h0000_0150);
        chk("R7 prev_sup", 32'(prev_sup), 1);
        chk("R7 empty", 32'(q_count), 0);
    endtask

    task automatic t_order();
        do_reset();
        push_level(4'd2);
        push_level(4'd9);
        push_level(4'd5);
        chk("R9 three pending", 32'(q_count), 3);
        write_stat(0, 1, 4'd0);
        step();
        chk("R9 first highest", vec_reg, 32'h0000_0190);
        chk("R9 count 2", 32'(q_count), 2);
        write_stat(0, 1, 4'd0);
        step();
        chk("R9 second", vec_reg, 32'h0000_0150);
        write_stat(0, 1, 4'd0);
        step();
        chk("R9 third", vec_reg, 32'h0000_0120);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 0; i < 8; i++) push_level(4'(i));
        chk("R10 full count", 32'(q_count), 8);
        chk("R10 no overflow yet", 32'(q_overflow), 0);
        push_level(4'd12);
        chk("R10 dropped", 32'(q_count), 8);
        chk("R10 overflow", 32'(q_overflow), 1);
        write_stat(0, 1, 4'd0);
        step();
        chk("R10 dropped level absent", vec_reg, 32'h0000_0170);
        step();
        chk("R10 overflow sticky", 32'(q_overflow), 1);
    endtask

    task automatic t_priority();
        do_reset();
        push_level(4'd7);
        wr_stat = 1; wr_sup = 0; wr_trap_en = 1; wr_floor = 0;
        step();
        wr_stat = 0;
        sync_trap(2'd2, 0, 8'h00, 32'h0000_0900, 32'h0);
        chk("R11 break wins", vec_reg, 32'h0000_0FF0);
        chk("R11 ext stays", 32'(q_count), 1);
        wr_stat = 1; wr_sup = 0; wr_trap_en = 1; wr_floor = 0;
        step();
        wr_stat = 0;
        sync_trap(2'd0, 0, 8'h33, 32'h0000_0A00, 32'h0);
        chk("R11 sync wins", vec_reg, 32'h0000_0330);
        chk("R11 ext still pending", 32'(q_count), 1);
    endtask

    task automatic t_write_collision();
        do_reset();
        write_stat(1, 1, 4'd0);
        wr_stat = 1; wr_sup = 0; wr_trap_en = 1; wr_floor = 4'd9;
        wr_vec = 1; wr_vec_base = 20'h55555;
        sync_trap(2'd1, 0, 8'h01, 32'h0, 32'h0);
        wr_stat = 0; wr_vec = 0;
        chk("R12 floor write dropped", 32'(irq_floor), 0);
        chk("R12 base write dropped", vec_reg, 32'h0000_0010);
        write_stat(0, 0, 4'd9);
        chk("R12 floor written", 32'(irq_floor), 9);
        chk("R12 sup written", 32'(sup), 0);
        write_base(20'h55555);
        chk("R12 base written", vec_reg, 32'h5555_5010);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        step();
        t_reset();
        t_break();
        t_program_precise();
        t_software_imprecise();
        t_halt();
        t_ext_mask();
        t_order();
        t_overflow();
        t_priority();
        t_write_collision();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule